// File: doc/BRIEF.md
# Fractional Baud-Rate Clock Generator

This block produces the oversampling clock enable for one serial channel. A fast reference clock is first slowed by an integer prescaler. A counter then divides the prescaled rate by an integer-plus-sixteenths divisor. A rate-mode field picks how many output ticks make up one bit time. The result is a single-cycle `tick` enable for the receive and transmit samplers. A derived square wave, `obs_clk`, toggles on every tick.

Software sets the `clk_off` hold bit, rewrites the divisor fields, and then clears the bit. Counting restarts cleanly from the new settings. For bench or board checks, `obs_clk` can replace the normal request-to-send level on `rts_out`. With a nonzero fractional part, consecutive tick periods differ by one prescaled cycle. Only the long-run average rate is exact.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and with `clk_off` held high, `tick` and `obs_clk` are 0.
- R2: The prescaler divides the reference by `pre_div` (1 to 63). A value of 0 acts as 1. Every tick interval is a multiple of that factor in reference cycles.
- R3: With `frac_div`=0, the divider emits one internal tick every `int_div` prescaled cycles. An `int_div` of 0 acts as 1.
- R4: With fraction F and divisor D, internal tick k ends after k*D + floor(k*F/16) prescaled cycles, counted from release. Each internal period is therefore D or D+1.
- R5: `rate_mode` sets how many internal ticks make one output tick: 2'b00 → 1 (16x), 2'b01 → 2 (8x), 2'b10 → 4 (4x), 2'b11 → 1 (same as 2'b00).
- R6: While `clk_off` is high, no tick is produced and all counters restart. After release, output tick j appears N*(j*M*D + floor(j*M*F/16)) reference cycles after the first enabled edge, using the settings applied during the hold.
- R7: `tick` is a one-cycle pulse. It is never high on two consecutive cycles unless the expected interval is 1.
- R8: `obs_clk` inverts on exactly the cycles where `tick` is high. It holds its value otherwise.
- R9: `rts_out` equals `obs_clk` when `rts_sel` is 1, and equals `rts_in` when `rts_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_div | input | 6 | Prescaler factor (0 treated as 1) |
| int_div | input | 16 | Integer divisor (0 treated as 1) |
| frac_div | input | 4 | Fractional divisor in sixteenths |
| rate_mode | input | 2 | Oversampling multiple select |
| clk_off | input | 1 | Hold: stops and clears the generator |
| rts_sel | input | 1 | Route `obs_clk` onto `rts_out` |
| rts_in | input | 1 | Normal request-to-send level |
| tick | output | 1 | One-cycle oversampling enable |
| obs_clk | output | 1 | Square wave toggling per tick |
| rts_out | output | 1 | Request-to-send output after the mux |

## Verification
The bench builds the block with its default widths: a 6-bit prescaler, a 16-bit integer divisor and a 4-bit fraction. These widths make the largest prescaler value, 63, reachable in a short run. Each run uses small integer divisors, so many fractional carry patterns fit within a few hundred cycles. Fractions of 5, 8 and 15 exercise sparse, even and near-every-period carries. The zero codes for prescaler and divisor, and all four rate-mode codes, are each driven in their own run, with a hold-and-reprogram sequence between runs.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  typedef enum logic [1:0] {
    RATE_X16  = 2'b00,
    RATE_X8   = 2'b01,
    RATE_X4   = 2'b10,
    RATE_X16B = 2'b11
  } rate_e;

  // Last index of the post-divide counter: internal ticks per output tick, minus one.
  function automatic logic [1:0] post_last(input rate_e m);
    case (m)
      RATE_X8: return 2'd1;
      RATE_X4: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/baudgen_prediv.sv
module baudgen_prediv #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [PRE_W-1:0] div,
  output logic             pre_en
);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] last;

  function automatic logic [PRE_W-1:0] last_of(input logic [PRE_W-1:0] d);
    return (d == '0) ? '0 : d - PRE_W'(1);
  endfunction

  assign last   = last_of(div);
  assign pre_en = !hold && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) cnt <= '0;
    else if (pre_en)    cnt <= '0;
    else                cnt <= cnt + PRE_W'(1);
  end

endmodule

// File: rtl/baudgen_fracdiv.sv
module baudgen_fracdiv #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              pre_en,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac,
  output logic              core_tick,
  output logic              carry
);

  localparam int CW = INT_W + 1;

  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [CW-1:0]     last;

  function automatic logic carry_of(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] f);
    logic [FRAC_W:0] s;
    s = {1'b0, a} + {1'b0, f};
    return s[FRAC_W];
  endfunction

  function automatic logic [CW-1:0] period_last(input logic [INT_W-1:0] d, input logic c);
    logic [CW-1:0] de;
    de = (d == '0) ? CW'(1) : {1'b0, d};
    return de - CW'(1) + CW'(c);
  endfunction

  assign carry     = carry_of(acc, frac);
  assign last      = period_last(int_div, carry);
  assign core_tick = pre_en && ({1'b0, cnt} >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      cnt <= '0;
      acc <= '0;
    end else if (core_tick) begin
      cnt <= '0;
      acc <= acc + frac;
    end else if (pre_en) begin
      cnt <= cnt + INT_W'(1);
    end
  end

endmodule

// File: rtl/baudgen_postdiv.sv
module baudgen_postdiv
  import baudgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  core_tick,
  input  rate_e mode,
  output logic  tick_c
);

  logic [1:0] pcnt;
  logic [1:0] last;

  assign last   = post_last(mode);
  assign tick_c = core_tick && (pcnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) pcnt <= '0;
    else if (tick_c)    pcnt <= '0;
    else if (core_tick) pcnt <= pcnt + 2'd1;
  end

endmodule

// File: rtl/baudgen_outstage.sv
module baudgen_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick_c,
  input  logic rts_sel,
  input  logic rts_in,
  output logic tick,
  output logic obs_clk,
  output logic rts_out
);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      tick    <= 1'b0;
      obs_clk <= 1'b0;
    end else begin
      tick    <= tick_c;
      obs_clk <= obs_clk ^ tick_c;
    end
  end

  assign rts_out = rts_sel ? obs_clk : rts_in;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baudgen_pkg::*;
#(
  parameter int PRE_W  = 6,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  pre_div,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac_div,
  input  logic [1:0]        rate_mode,
  input  logic              clk_off,
  input  logic              rts_sel,
  input  logic              rts_in,
  output logic              tick,
  output logic              obs_clk,
  output logic              rts_out
);

  logic  pre_en;
  logic  core_tick;
  logic  carry;
  logic  tick_c;
  rate_e mode;

  assign mode = rate_e'(rate_mode);

  baudgen_prediv #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .hold(clk_off), .div(pre_div), .pre_en(pre_en)
  );

  baudgen_fracdiv #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .hold(clk_off), .pre_en(pre_en),
    .int_div(int_div), .frac(frac_div), .core_tick(core_tick), .carry(carry)
  );

  baudgen_postdiv u_post (
    .clk(clk), .rst_n(rst_n), .hold(clk_off), .core_tick(core_tick),
    .mode(mode), .tick_c(tick_c)
  );

  baudgen_outstage u_out (
    .clk(clk), .rst_n(rst_n), .hold(clk_off), .tick_c(tick_c),
    .rts_sel(rts_sel), .rts_in(rts_in),
    .tick(tick), .obs_clk(obs_clk), .rts_out(rts_out)
  );

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_off,
  input logic              tick,
  input logic              obs_clk,
  input logic              pre_en,
  input logic              core_tick,
  input logic              carry,
  input logic [FRAC_W-1:0] frac_div
);

  // R6: a hold seen on one edge leaves no tick after it
  p_tick_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_off) |-> !tick);

  // R8: the square wave inverts whenever a tick is presented
  p_obs_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (obs_clk != $past(obs_clk)));

  // R8: with no tick and no hold, the square wave keeps its level
  p_obs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !$past(clk_off)) |-> $stable(obs_clk));

  // R3: an internal tick only lands on a prescaled cycle
  p_core_on_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_tick |-> pre_en);

  // R4: the extra cycle needs a nonzero fraction
  p_carry_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (frac_div != '0));

  // R5: every output tick comes from an internal tick one cycle earlier
  p_tick_from_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !$past(clk_off)) |-> $past(core_tick));

endmodule

bind baud_tick_gen baud_tick_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_off(clk_off), .tick(tick), .obs_clk(obs_clk),
  .pre_en(pre_en), .core_tick(core_tick), .carry(carry), .frac_div(frac_div)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  pre_div = 6'd1;
  logic [15:0] int_div = 16'd1;
  logic [3:0]  frac_div = 4'd0;
  logic [1:0]  rate_mode = 2'b00;
  logic        clk_off = 1'b1;
  logic        rts_sel = 1'b0;
  logic        rts_in = 1'b0;
  logic        tick, obs_clk, rts_out;

  baud_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .pre_div(pre_div), .int_div(int_div),
    .frac_div(frac_div), .rate_mode(rate_mode), .clk_off(clk_off),
    .rts_sel(rts_sel), .rts_in(rts_in),
    .tick(tick), .obs_clk(obs_clk), .rts_out(rts_out)
  );

  always #5 clk = ~clk;

  int    nchk = 0;
  int    nerr = 0;
  int    q[$];
  string tag = "R1";
  bit    live = 1'b0;
  int    gap = 0;
  bit    exp_obs = 1'b0;
  bit    prev_tick = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) live <= rst_n && !clk_off;

  always @(posedge clk) begin
    #1 rts_in = $urandom_range(0, 1);
  end

  // Monitor: pops the expected interval on each tick
  always @(negedge clk) begin
    if (!live) begin
      gap = 0; exp_obs = 1'b0; prev_tick = 1'b0;
      if (tick) check(1'b0, "R6", "tick while held", 1, 0);
    end else begin
      gap++;
      if (tick) begin
        int e;
        if (q.size() == 0) begin
          e = 0;
          check(1'b0, "R6", "unexpected tick", gap, 0);
        end else begin
          e = q.pop_front();
          check(gap == e, tag, "tick interval", gap, e);
        end
        check(obs_clk == !exp_obs, "R8", "obs_clk toggle", obs_clk, !exp_obs);
        exp_obs = !exp_obs;
        check(rts_out == (rts_sel ? obs_clk : rts_in), "R9", "rts_out mux",
              rts_out, rts_sel ? obs_clk : rts_in);
        if (e > 1) check(!prev_tick, "R7", "tick width", prev_tick, 0);
        gap = 0;
      end
      prev_tick = tick;
    end
  end

  function automatic longint edge_of(int n, int d, int f, int m, int j);
    longint k = longint'(j) * m;
    return longint'(n) * (k * d + (k * f) / 16);
  endfunction

  // Driver: programs while held, pushes expected intervals, releases
  task automatic run_cfg(input string t, input int n, input int d, input int f,
                         input logic [1:0] mode, input bit sel, input int count);
    int ne = (n == 0) ? 1 : n;
    int de = (d == 0) ? 1 : d;
    int m  = (mode == 2'b01) ? 2 : (mode == 2'b10) ? 4 : 1;
    @(negedge clk);
    clk_off = 1'b1;
    repeat (2) @(negedge clk);
    check(tick == 1'b0 && obs_clk == 1'b0, "R6", "held outputs", {tick, obs_clk}, 0);
    pre_div = 6'(n); int_div = 16'(d); frac_div = 4'(f);
    rate_mode = mode; rts_sel = sel; tag = t;
    for (int j = 1; j <= count; j++)
      q.push_back(int'(edge_of(ne, de, f, m, j) - edge_of(ne, de, f, m, j - 1)));
    @(negedge clk);
    clk_off = 1'b0;
    wait (q.size() == 0);
    clk_off = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tick == 1'b0 && obs_clk == 1'b0, "R1", "reset outputs", {tick, obs_clk}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tick == 1'b0 && obs_clk == 1'b0, "R1", "held after reset", {tick, obs_clk}, 0);
    run_cfg("R3", 1, 5, 0, 2'b00, 1'b0, 6);
    run_cfg("R3", 1, 0, 0, 2'b00, 1'b1, 5);
    run_cfg("R2", 3, 4, 0, 2'b00, 1'b0, 5);
    run_cfg("R2", 0, 3, 0, 2'b00, 1'b1, 5);
    run_cfg("R2", 63, 2, 0, 2'b00, 1'b0, 4);
    run_cfg("R4", 1, 3, 5, 2'b00, 1'b1, 20);
    run_cfg("R4", 2, 7, 15, 2'b00, 1'b0, 12);
    run_cfg("R4", 1, 2, 8, 2'b00, 1'b1, 10);
    run_cfg("R5", 1, 3, 3, 2'b01, 1'b0, 8);
    run_cfg("R5", 2, 2, 0, 2'b10, 1'b1, 6);
    run_cfg("R5", 1, 4, 6, 2'b11, 1'b0, 8);
    run_cfg("R6", 2, 6, 9, 2'b01, 1'b1, 6);
    repeat (3) @(negedge clk);
    check(tick == 1'b0 && obs_clk == 1'b0, "R6", "final hold", {tick, obs_clk}, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule